// File: doc/BRIEF.md
# Lookup-Table Trigger Term Evaluator

This block judges a stream of 32-bit samples against a bank of trigger terms and reports one hit bit per term. There are ten masked-match terms, two window (range) terms, two transition terms and two interval timers. Every comparison is made by 16-entry lookup tables, each table seeing four input bits. The tables are loaded at run time through a bit-serial configuration port, so software can give each term any per-nibble match function: equality under a mask, "don't care", parity, and so on.

Configuration works in two steps. An address strobe picks one 16-bit table. Each data strobe then shifts one bit into that table. The interval timers take their limits from the same table storage. A separate sequencer consumes the hit vector and combines the terms into trigger decisions.

Top module: `trig_term_eval`

## Requirements
- R1: After reset every table holds zero, the previous-sample register is zero, every timer is idle with a count of zero, and `term_hit` is all zeros. A valid sample applied with all-zero tables leaves every comparator hit at 0.
- R2: A pulse on `cfg_sel_we` latches `cfg_sel_addr` as the selected table. Each pulse on `cfg_bit_we` shifts `cfg_bit` into bit 0 of the selected table and moves the older bits one place toward bit 15, so sixteen pulses load a word MSB first. No other table changes. A selected address at or above 182 makes the bit strobes have no effect.
- R3: Match term t (t = 0..9, hit bit t) uses tables 8t+n for nibble n (n = 0..7, nibble n being sample bits 4n+3..4n). The term hits when, for every n, entry sample[4n+3:4n] of its table is 1.
- R4: Range term r (r = 0..1, hit bit 10+r) uses table 80+32r+8p+n, where p = 0 is "nibble above low", p = 1 is "nibble equals low", p = 2 is "nibble below high" and p = 3 is "nibble equals high". Each bound is resolved from the most significant nibble down: a strict entry decides at once, and an equal entry defers to the next lower nibble. When all nibbles are equal, the bound counts as met. The term hits when both bounds are met.
- R5: Edge term e (e = 0..1, hit bit 12+e) uses table 144+16e+k for bit pair k (k = 0..15). The index is {cur[2k+1], prev[2k+1], cur[2k], prev[2k]}, written MSB to LSB. The term hits when any of its 16 tables returns 1.
- R6: The previous sample used by the edge terms is the most recent sample presented with `sample_vld` high.
- R7: Hit bits 0..13 update on the clock edge that accepts a valid sample and are visible right after it. While `sample_vld` is low they hold, and the previous sample is not updated.
- R8: The limit of timer t (hit bit 14+t) is the 48-bit value held in tables 176+3t+w, with table w supplying bits 16w+15..16w. A start sampled at edge E0 makes the counter advance by one on each later edge. Its hit rises on edge E0+L+1 for a limit L, at which point counting stops.
- R9: Once a timer hit is set, it and the count stay unchanged until a clear.
- R10: Timer controls act on the edge that samples them, with clear taking precedence over stop and stop over start. Clear zeroes the count, stops the timer and drops the hit. A stop still lets the count advance on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 32 | Sample word |
| sample_vld | input | 1 | Sample qualifier |
| tmr_start | input | 2 | Per-timer start |
| tmr_stop | input | 2 | Per-timer stop |
| tmr_clear | input | 2 | Per-timer clear |
| cfg_sel_we | input | 1 | Table select strobe |
| cfg_sel_addr | input | 8 | Table index |
| cfg_bit_we | input | 1 | Serial bit strobe |
| cfg_bit | input | 1 | Serial configuration bit |
| term_hit | output | 16 | Hits: match 9..0, range 11..10, edge 13..12, timer 15..14 |

## Verification
The sweeps place samples exactly at each window bound and one below and above it. A carry chain that stopped at the first equal nibble, or that treated "all equal" as a miss, would reject the bounds themselves. Samples with the qualifier low carry changing data. A design that let them through would move the hits or corrupt the previous sample, and later edge results would go wrong. The timer checks count edges from the start pulse, including a stop that lands mid-run, a zero limit, and clear or stop colliding with start. Off-by-one counting or wrong control precedence shows up as a hit one cycle early or late, or as a spurious hit.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int LUT_W  = 16;
    localparam int LUT_IN = 4;

    typedef enum logic [1:0] {
        RP_ABOVE_LO = 2'd0,
        RP_EQ_LO    = 2'd1,
        RP_BELOW_HI = 2'd2,
        RP_EQ_HI    = 2'd3
    } range_part_e;

    localparam int RANGE_PARTS = 4;
endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
    import trig_pkg::*;
#(
    parameter int N_ELEM = 182,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_we,
    input  logic [ADDR_W-1:0]         sel_addr,
    input  logic                      bit_we,
    input  logic                      bit_in,
    output logic [N_ELEM*LUT_W-1:0]   tables_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]       sel;
        logic [N_ELEM*LUT_W-1:0] tab;
    } cfg_t;

    cfg_t st_d, st_q;
    logic sel_ok;

    assign sel_ok = ({1'b0, st_q.sel} < (ADDR_W+1)'(N_ELEM));

    always_comb begin
        st_d = st_q;
        if (bit_we && sel_ok) begin
            for (int e = 0; e < N_ELEM; e++) begin
                if (e == int'(st_q.sel)) begin
                    st_d.tab[e*LUT_W +: LUT_W] = {st_q.tab[e*LUT_W +: LUT_W-1], bit_in};
                end
            end
        end
        if (sel_we) begin
            st_d.sel = sel_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tables_o = st_q.tab;

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_we |=> $stable(tables_o));
endmodule

// File: rtl/trig_mag_chain.sv
module trig_mag_chain #(
    parameter int NIB = 8
) (
    input  logic [NIB-1:0] strict_i,
    input  logic [NIB-1:0] eq_i,
    output logic           ok_o
);
    logic [NIB:0] carry;

    assign carry[0] = 1'b1;
    for (genvar i = 0; i < NIB; i++) begin : g_link
        assign carry[i+1] = strict_i[i] | (eq_i[i] & carry[i]);
    end
    assign ok_o = carry[NIB];
endmodule

// File: rtl/trig_interval_timer.sv
module trig_interval_timer #(
    parameter int TIMER_W = 36,
    parameter int LIM_W   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             clear,
    input  logic [LIM_W-1:0] limit,
    output logic             hit_o
);
    typedef struct packed {
        logic               run;
        logic               done;
        logic [TIMER_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else begin
            if (st_q.run && !st_q.done) begin
                if (LIM_W'(st_q.cnt) == limit) begin
                    st_d.done = 1'b1;
                    st_d.run  = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (stop)       st_d.run = 1'b0;
            else if (start) st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.done;

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clear) |=> st_q.done);
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clear) |=> $stable(st_q.cnt));
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!st_q.done && !st_q.run && st_q.cnt == '0));
endmodule

// File: rtl/trig_term_eval.sv
module trig_term_eval
    import trig_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int N_MATCH  = 10,
    parameter int N_RANGE  = 2,
    parameter int N_EDGE   = 2,
    parameter int N_TIMER  = 2,
    parameter int TIMER_W  = 36,
    localparam int NIB        = SAMPLE_W / LUT_IN,
    localparam int PAIRS      = SAMPLE_W / 2,
    localparam int TL_ELEMS   = (TIMER_W + LUT_W - 1) / LUT_W,
    localparam int RANGE_BASE = N_MATCH * NIB,
    localparam int EDGE_BASE  = RANGE_BASE + N_RANGE * RANGE_PARTS * NIB,
    localparam int TMR_BASE   = EDGE_BASE + N_EDGE * PAIRS,
    localparam int N_ELEM     = TMR_BASE + N_TIMER * TL_ELEMS,
    localparam int ADDR_W     = $clog2(N_ELEM),
    localparam int N_CMP      = N_MATCH + N_RANGE + N_EDGE,
    localparam int N_TERM     = N_CMP + N_TIMER
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_vld,
    input  logic [N_TIMER-1:0]  tmr_start,
    input  logic [N_TIMER-1:0]  tmr_stop,
    input  logic [N_TIMER-1:0]  tmr_clear,
    input  logic                cfg_sel_we,
    input  logic [ADDR_W-1:0]   cfg_sel_addr,
    input  logic                cfg_bit_we,
    input  logic                cfg_bit,
    output logic [N_TERM-1:0]   term_hit
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] prev;
        logic [N_CMP-1:0]    hit;
    } eval_t;

    eval_t st_d, st_q;

    logic [N_ELEM*LUT_W-1:0] tables;
    logic [N_MATCH-1:0]      match_now;
    logic [N_RANGE-1:0]      range_now;
    logic [N_EDGE-1:0]       edge_now;
    logic [N_TIMER-1:0]      tmr_hit;

    trig_cfg_store #(.N_ELEM(N_ELEM), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (cfg_sel_we),
        .sel_addr (cfg_sel_addr),
        .bit_we   (cfg_bit_we),
        .bit_in   (cfg_bit),
        .tables_o (tables)
    );

    // Masked match terms: one table per nibble, results ANDed.
    for (genvar t = 0; t < N_MATCH; t++) begin : g_match
        logic [NIB-1:0] nib_ok;
        for (genvar n = 0; n < NIB; n++) begin : g_nib
            localparam int EL = t * NIB + n;
            logic [LUT_W-1:0] tbl;
            assign tbl       = tables[EL*LUT_W +: LUT_W];
            assign nib_ok[n] = tbl[sample[LUT_IN*n +: LUT_IN]];
        end
        assign match_now[t] = &nib_ok;
    end

    // Window terms: per-nibble relations resolved by a carry chain.
    for (genvar r = 0; r < N_RANGE; r++) begin : g_range
        logic [NIB-1:0] rel [RANGE_PARTS];
        logic lo_ok, hi_ok;
        for (genvar p = 0; p < RANGE_PARTS; p++) begin : g_part
            for (genvar n = 0; n < NIB; n++) begin : g_nib
                localparam int EL = RANGE_BASE + (r * RANGE_PARTS + p) * NIB + n;
                logic [LUT_W-1:0] tbl;
                assign tbl       = tables[EL*LUT_W +: LUT_W];
                assign rel[p][n] = tbl[sample[LUT_IN*n +: LUT_IN]];
            end
        end
        trig_mag_chain #(.NIB(NIB)) u_lo (
            .strict_i (rel[int'(RP_ABOVE_LO)]),
            .eq_i     (rel[int'(RP_EQ_LO)]),
            .ok_o     (lo_ok)
        );
        trig_mag_chain #(.NIB(NIB)) u_hi (
            .strict_i (rel[int'(RP_BELOW_HI)]),
            .eq_i     (rel[int'(RP_EQ_HI)]),
            .ok_o     (hi_ok)
        );
        assign range_now[r] = lo_ok & hi_ok;
    end

    // Transition terms: one table per bit pair, current vs previous valid sample.
    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        logic [PAIRS-1:0] pair_hit;
        for (genvar k = 0; k < PAIRS; k++) begin : g_pair
            localparam int EL = EDGE_BASE + e * PAIRS + k;
            logic [LUT_W-1:0]  tbl;
            logic [LUT_IN-1:0] idx;
            assign tbl = tables[EL*LUT_W +: LUT_W];
            assign idx = {sample[2*k+1], st_q.prev[2*k+1], sample[2*k], st_q.prev[2*k]};
            assign pair_hit[k] = tbl[idx];
        end
        assign edge_now[e] = |pair_hit;
    end

    // Interval timers with limits taken from table storage.
    for (genvar t = 0; t < N_TIMER; t++) begin : g_tmr
        localparam int EL = TMR_BASE + t * TL_ELEMS;
        trig_interval_timer #(.TIMER_W(TIMER_W), .LIM_W(TL_ELEMS*LUT_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (tmr_start[t]),
            .stop  (tmr_stop[t]),
            .clear (tmr_clear[t]),
            .limit (tables[EL*LUT_W +: TL_ELEMS*LUT_W]),
            .hit_o (tmr_hit[t])
        );
    end

    always_comb begin
        st_d = st_q;
        if (sample_vld) begin
            st_d.prev = sample;
            st_d.hit  = {edge_now, range_now, match_now};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign term_hit = {tmr_hit, st_q.hit};

    p_hold_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(term_hit[N_CMP-1:0]));
    p_timer_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tmr_hit[0])) |-> !$past(tmr_clear[0]));
endmodule

// File: tb/tb_trig_term_eval.sv
module tb_trig_term_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sample = '0;
    logic        sample_vld = 1'b0;
    logic [1:0]  tmr_start = '0, tmr_stop = '0, tmr_clear = '0;
    logic        cfg_sel_we = 1'b0;
    logic [7:0]  cfg_sel_addr = '0;
    logic        cfg_bit_we = 1'b0;
    logic        cfg_bit = 1'b0;
    logic [15:0] term_hit;

    int n_cmp = 0;
    int n_bad = 0;

    trig_term_eval dut (
        .clk(clk), .rst_n(rst_n), .sample(sample), .sample_vld(sample_vld),
        .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tmr_clear(tmr_clear),
        .cfg_sel_we(cfg_sel_we), .cfg_sel_addr(cfg_sel_addr),
        .cfg_bit_we(cfg_bit_we), .cfg_bit(cfg_bit), .term_hit(term_hit)
    );

    always #10 clk = ~clk;

    logic [31:0] mval [10];
    logic [31:0] mmask [10];
    logic [31:0] rlo [2];
    logic [31:0] rhi [2];
    logic [1:0]  emode [2][32];   // 0 none, 1 rise, 2 fall, 3 both
    logic [31:0] prev_s = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_elem(int a, logic [15:0] v);
        cfg_sel_we = 1'b1;
        cfg_sel_addr = 8'(a);
        step();
        cfg_sel_we = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            cfg_bit_we = 1'b1;
            cfg_bit = v[i];
            step();
        end
        cfg_bit_we = 1'b0;
    endtask

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    function automatic logic edge_fn(logic [1:0] m, logic c, logic p);
        return ((m == 2'd1 || m == 2'd3) && c && !p) ||
               ((m == 2'd2 || m == 2'd3) && !c && p);
    endfunction

    function automatic logic [9:0] exp_match(logic [31:0] s);
        logic [9:0] r;
        for (int t = 0; t < 9; t++) r[t] = (((s ^ mval[t]) & mmask[t]) == 32'h0);
        r[9] = 1'b1;
        for (int n = 0; n < 8; n++) if (!(^s[4*n +: 4])) r[9] = 1'b0;
        return r;
    endfunction

    function automatic logic [1:0] exp_range(logic [31:0] s);
        logic [1:0] r;
        for (int i = 0; i < 2; i++) r[i] = (s >= rlo[i]) && (s <= rhi[i]);
        return r;
    endfunction

    function automatic logic [1:0] exp_edge(logic [31:0] s, logic [31:0] p);
        logic [1:0] r = '0;
        for (int e = 0; e < 2; e++)
            for (int b = 0; b < 32; b++)
                if (edge_fn(emode[e][b], s[b], p[b])) r[e] = 1'b1;
        return r;
    endfunction

    task automatic load_all();
        logic [15:0] w;
        for (int t = 0; t < 10; t++)
            for (int n = 0; n < 8; n++) begin
                if (t == 9) begin
                    for (int v = 0; v < 16; v++) w[v] = ^(4'(v));
                end else if (mmask[t][4*n +: 4] == 4'h0) begin
                    w = 16'hFFFF;
                end else begin
                    w = 16'h1 << mval[t][4*n +: 4];
                end
                load_elem(t*8 + n, w);
            end
        for (int r = 0; r < 2; r++)
            for (int p = 0; p < 4; p++)
                for (int n = 0; n < 8; n++) begin
                    for (int v = 0; v < 16; v++) begin
                        case (p)
                            0: w[v] = v > int'(rlo[r][4*n +: 4]);
                            1: w[v] = v == int'(rlo[r][4*n +: 4]);
                            2: w[v] = v < int'(rhi[r][4*n +: 4]);
                            default: w[v] = v == int'(rhi[r][4*n +: 4]);
                        endcase
                    end
                    load_elem(80 + 32*r + 8*p + n, w);
                end
        for (int e = 0; e < 2; e++)
            for (int k = 0; k < 16; k++) begin
                for (int v = 0; v < 16; v++) begin
                    logic [3:0] ix = 4'(v);
                    w[v] = edge_fn(emode[e][2*k], ix[1], ix[0]) ||
                           edge_fn(emode[e][2*k+1], ix[3], ix[2]);
                end
                load_elem(144 + 16*e + k, w);
            end
    endtask

    task automatic sweep(int cnt, string tag);
        logic [31:0] bnd [4];
        logic [13:0] last_exp = dut.term_hit[13:0];
        bnd[0] = rlo[0]; bnd[1] = rhi[0]; bnd[2] = rlo[1]; bnd[3] = rhi[1];
        for (int i = 0; i < cnt; i++) begin
            logic [31:0] s;
            logic v;
            lfsr = next_rand(lfsr);
            case (i % 4)
                0: s = mval[(i/4) % 10];
                1: s = mval[(i/4) % 10] ^ (32'h1 << (4 * ((i/4) % 8)));
                2: s = bnd[(i/4) % 4] + 32'((i/16) % 3) - 32'd1;
                default: s = lfsr;
            endcase
            v = (i % 5) != 4;
            sample = s;
            sample_vld = v;
            step();
            if (v) begin
                last_exp = {exp_edge(s, prev_s), exp_range(s), exp_match(s)};
                prev_s = s;
                chk({"R3 match ", tag}, 64'(term_hit[9:0]), 64'(last_exp[9:0]));
                chk({"R4 range ", tag}, 64'(term_hit[11:10]), 64'(last_exp[11:10]));
                chk({"R5 R6 edge ", tag}, 64'(term_hit[13:12]), 64'(last_exp[13:12]));
            end else begin
                chk({"R7 hold ", tag}, 64'(term_hit[13:0]), 64'(last_exp));
            end
        end
        sample_vld = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < 10; t++) begin
            mval[t] = 32'hA5C3_1E70 ^ (32'(t) * 32'h0F1E_2D3C);
            mmask[t] = '0;
            for (int n = 0; n < 8; n++)
                if (t == 0 || ((t + n) % 3) != 0) mmask[t][4*n +: 4] = 4'hF;
        end
        mval[9] = 32'h1248_7BDE;
        rlo[0] = 32'h1234_5600; rhi[0] = 32'h1234_56FF;
        rlo[1] = 32'h0000_0010; rhi[1] = 32'hF000_0000;
        for (int e = 0; e < 2; e++)
            for (int b = 0; b < 32; b++) emode[e][b] = 2'd0;
        emode[0][0] = 2'd1; emode[0][1] = 2'd2; emode[0][7] = 2'd3;
        emode[1][31] = 2'd2; emode[1][16] = 2'd3; emode[1][9] = 2'd1;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset hits", 64'(term_hit), 64'h0);
        sample = 32'hFFFF_FFFF; sample_vld = 1'b1;
        step();
        sample_vld = 1'b0;
        chk("R1 zero tables", 64'(term_hit), 64'h0);
        prev_s = 32'hFFFF_FFFF;

        load_all();
        sweep(400, "sweep");

        // R2: out-of-range select, strobes must change nothing
        load_elem(250, 16'hFFFF);
        load_elem(181, 16'h0000);
        sweep(40, "R2 after bad select");

        // R8: timer0 limit 3, timer1 limit 0
        load_elem(176, 16'd3);
        tmr_start = 2'b11; step(); tmr_start = 2'b00;
        for (int i = 1; i <= 6; i++) begin
            step();
            chk("R8 timer0 limit3", 64'(term_hit[14]), 64'(i >= 4));
            chk("R8 timer1 limit0", 64'(term_hit[15]), 64'h1);
        end
        chk("R9 sticky", 64'(term_hit[15:14]), 64'h3);
        tmr_clear = 2'b11; step(); tmr_clear = 2'b00;
        chk("R10 clear drops hit", 64'(term_hit[15:14]), 64'h0);

        // R10: stop mid-run still counts on its own edge
        load_elem(176, 16'd5);
        tmr_start = 2'b01; step(); tmr_start = 2'b00;
        step(); step();
        tmr_stop = 2'b01; step(); tmr_stop = 2'b00;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R10 stopped timer0", 64'(term_hit[14]), 64'h0);
        end
        tmr_start = 2'b01; step(); tmr_start = 2'b00;
        step(); chk("R8 resume 1", 64'(term_hit[14]), 64'h0);
        step(); chk("R8 resume 2", 64'(term_hit[14]), 64'h0);
        step(); chk("R8 resume 3", 64'(term_hit[14]), 64'h1);
        tmr_clear = 2'b01; step(); tmr_clear = 2'b00;

        // R10 precedence: clear beats start, stop beats start
        tmr_start = 2'b10; tmr_clear = 2'b10; step();
        tmr_start = 2'b00; tmr_clear = 2'b00;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R10 clear over start", 64'(term_hit[15]), 64'h0);
        end
        tmr_start = 2'b10; tmr_stop = 2'b10; step();
        tmr_start = 2'b00; tmr_stop = 2'b00;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R10 stop over start", 64'(term_hit[15]), 64'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule